// File: doc/BRIEF.md
# Four-Phase Dual-Rail Channel Interface

This block links a single-rail producer and a single-rail consumer over a dual-rail bus. Each data bit travels on two wires, a true rail and a false rail. There is no separate request wire: a word counts as present once every bit pair carries a legal value. The transmit half takes a parallel word with a valid strobe and places it on its rail outputs. The receive half watches its rail inputs. A completion detector in the receive half drives the acknowledge level, and the receive half also returns the word in single-rail form.

A transfer runs in four phases. First, the word goes out on the rails. Second, the acknowledge rises. Third, every rail returns to the empty spacer. Fourth, the acknowledge falls. Only then may a new word go out.

The two halves have separate ports. In normal use the transmit rails feed the receive rails and the receive acknowledge feeds the transmit acknowledge. Keeping the ports apart lets a test or a neighbouring block drive either side on its own. The model is synchronous: every rail and every acknowledge is registered on a single clock.

Top module: `dualrail_link`

## Requirements
- R1: For an accepted word, each bit that is 1 appears on the transmit rails as true=1, false=0. Each bit that is 0 appears as true=0, false=1. The transmit rails never show true=1 and false=1 on the same bit.
- R2: While reset is held and just after it, all transmit rails are 0, rxAck is 0, outValid is 0, codeErr is 0 and inReady is 1.
- R3: A word is accepted only on a clock edge where inReady is 1 and inValid is 1. inReady is 1 only when the transmitter is idle with an all-empty bus and txAck is 0. An inValid that arrives while inReady is 0 does not change the transmit rails.
- R4: After acceptance, the transmit rails hold the word unchanged while txAck stays 0. On the clock edge after the first edge with txAck at 1, every transmit rail goes to 0.
- R5: After that spacer, the transmitter keeps all rails at 0 and inReady at 0 while txAck stays 1. inReady returns to 1 on the edge after txAck is seen at 0.
- R6: rxAck rises on the first clock edge where every receive bit pair holds a legal data code, one of (1,0) or (0,1). While any pair is empty, rxAck stays 0.
- R7: rxAck falls on the first clock edge where every receive bit pair is (0,0). While any rail is still 1, rxAck stays 1.
- R8: outValid is a one-cycle pulse, raised on the same edge as rxAck rises. On that edge outWord takes the receive true rails.
- R9: codeErr goes to 1 on the edge after any receive bit pair is seen as (1,1). It stays 1 until reset.
- R10: A receive word with any pair at (1,1) is not complete and does not raise rxAck or outValid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inWord | input | W | Single-rail word to transmit |
| inValid | input | 1 | inWord is offered |
| inReady | output | 1 | Transmitter can accept a word on this edge |
| txRailT | output | W | Transmit true rails |
| txRailF | output | W | Transmit false rails |
| txAck | input | 1 | Acknowledge seen by the transmitter |
| rxRailT | input | W | Receive true rails |
| rxRailF | input | W | Receive false rails |
| rxAck | output | 1 | Completion acknowledge from the receiver |
| outWord | output | W | Decoded single-rail word |
| outValid | output | 1 | One-cycle pulse per completed token |
| codeErr | output | 1 | Sticky flag: an illegal (1,1) pair was seen |

## Verification
The checker assumes that the receive rails and txAck are synchronous to clk and follow the four-phase order, though a receive pair may be illegal at any time. In loopback the stimulus meets these assumptions by construction. When the bench drives the receive rails by hand, it moves them between empty, partly filled, complete and illegal patterns only on the falling clock edge. It never moves txAck in a way that breaks the hold rule the transmitter relies on.

// File: rtl/dr_pkg.sv
package dr_pkg;

  typedef enum logic [1:0] {
    ENC_IDLE = 2'd0,
    ENC_SEND = 2'd1,
    ENC_RTZ  = 2'd2
  } encState_e;

  typedef struct packed {
    logic loadTx;
    logic clearTx;
    logic capture;
  } ctrlStrobes_t;

  typedef struct packed {
    logic allValid;
    logic allEmpty;
  } rxStatus_t;

endpackage

// File: rtl/dr_datapath.sv
module dr_datapath
  import dr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] inWord,
  input  logic [W-1:0] rxRailT,
  input  logic [W-1:0] rxRailF,
  output logic [W-1:0] txRailT,
  output logic [W-1:0] txRailF,
  output logic [W-1:0] outWord,
  output logic         outValid,
  output logic         codeErr,
  output rxStatus_t    rxStatus
);

  logic [W-1:0] bitValid;
  logic [W-1:0] bitEmpty;
  logic [W-1:0] bitIllegal;

  // per-bit classification of the receive pairs
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign bitValid[b]   = rxRailT[b] ^ rxRailF[b];
    assign bitEmpty[b]   = ~(rxRailT[b] | rxRailF[b]);
    assign bitIllegal[b] = rxRailT[b] & rxRailF[b];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        txRailT[b] <= 1'b0;
        txRailF[b] <= 1'b0;
      end else if (strobes.clearTx) begin
        txRailT[b] <= 1'b0;
        txRailF[b] <= 1'b0;
      end else if (strobes.loadTx) begin
        txRailT[b] <= inWord[b];
        txRailF[b] <= ~inWord[b];
      end
    end
  end

  assign rxStatus.allValid = &bitValid;
  assign rxStatus.allEmpty = &bitEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWord  <= '0;
      outValid <= 1'b0;
      codeErr  <= 1'b0;
    end else begin
      outValid <= strobes.capture;
      if (strobes.capture) outWord <= rxRailT;
      if (|bitIllegal) codeErr <= 1'b1;
    end
  end

endmodule

// File: rtl/dr_control.sv
module dr_control
  import dr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         txAck,
  input  rxStatus_t    rxStatus,
  output ctrlStrobes_t strobes,
  output logic         inReady,
  output logic         rxAck
);

  encState_e encState, encNext;

  // transmit sequencing
  always_comb begin
    encNext         = encState;
    strobes.loadTx  = 1'b0;
    strobes.clearTx = 1'b0;
    unique case (encState)
      ENC_IDLE: if (inValid && !txAck) begin
        strobes.loadTx = 1'b1;
        encNext        = ENC_SEND;
      end
      ENC_SEND: if (txAck) begin
        strobes.clearTx = 1'b1;
        encNext         = ENC_RTZ;
      end
      ENC_RTZ: if (!txAck) encNext = ENC_IDLE;
      default: encNext = ENC_IDLE;
    endcase
  end

  assign inReady = (encState == ENC_IDLE) && !txAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) encState <= ENC_IDLE;
    else       encState <= encNext;
  end

  // completion detection on the receive side
  assign strobes.capture = !rxAck && rxStatus.allValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            rxAck <= 1'b0;
    else if (strobes.capture)             rxAck <= 1'b1;
    else if (rxAck && rxStatus.allEmpty)  rxAck <= 1'b0;
  end

endmodule

// File: rtl/dualrail_link.sv
module dualrail_link
  import dr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] inWord,
  input  logic         inValid,
  output logic         inReady,
  output logic [W-1:0] txRailT,
  output logic [W-1:0] txRailF,
  input  logic         txAck,
  input  logic [W-1:0] rxRailT,
  input  logic [W-1:0] rxRailF,
  output logic         rxAck,
  output logic [W-1:0] outWord,
  output logic         outValid,
  output logic         codeErr
);

  ctrlStrobes_t strobes;
  rxStatus_t    rxStatus;

  dr_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .txAck    (txAck),
    .rxStatus (rxStatus),
    .strobes  (strobes),
    .inReady  (inReady),
    .rxAck    (rxAck)
  );

  dr_datapath #(.W(W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inWord   (inWord),
    .rxRailT  (rxRailT),
    .rxRailF  (rxRailF),
    .txRailT  (txRailT),
    .txRailF  (txRailF),
    .outWord  (outWord),
    .outValid (outValid),
    .codeErr  (codeErr),
    .rxStatus (rxStatus)
  );

endmodule

// File: rtl/dr_checker.sv
module dr_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         inReady,
  input logic [W-1:0] txRailT,
  input logic [W-1:0] txRailF,
  input logic         txAck,
  input logic [W-1:0] rxRailT,
  input logic [W-1:0] rxRailF,
  input logic         rxAck,
  input logic         outValid,
  input logic         codeErr
);

  logic txEmpty;
  assign txEmpty = (txRailT == '0) && (txRailF == '0);

  AST_TX_NO_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (txRailT & txRailF) == '0);  // R1

  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !inReady) |=> txEmpty);  // R3

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!txEmpty && !txAck) |=> ($stable(txRailT) && $stable(txRailF)));  // R4

  AST_TX_RTZ: assert property (@(posedge clk) disable iff (!rstN)
    (!txEmpty && txAck) |=> txEmpty);  // R4

  AST_ACK_RISE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxAck) |-> $past((rxRailT ^ rxRailF) == {W{1'b1}}));  // R6

  AST_ACK_FALL_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxAck) |-> $past((rxRailT | rxRailF) == '0));  // R7

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);  // R8

  AST_VALID_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxAck) |-> outValid);  // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |=> codeErr);  // R9

  AST_ILLEGAL_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    ((rxRailT & rxRailF) != '0) |=> codeErr);  // R9

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |-> (!rxAck && !outValid && !codeErr && txEmpty));  // R2

  logic unusedIn;
  assign unusedIn = inValid;

endmodule

bind dualrail_link dr_checker #(.W(W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .txRailT  (txRailT),
  .txRailF  (txRailF),
  .txAck    (txAck),
  .rxRailT  (rxRailT),
  .rxRailF  (rxRailF),
  .rxAck    (rxAck),
  .outValid (outValid),
  .codeErr  (codeErr)
);

// File: tb/sim_dualrail_link.sv
module sim_dualrail_link;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] inWord = '0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [W-1:0] txRailT, txRailF;
  logic         txAck;
  logic [W-1:0] rxRailT, rxRailF;
  logic         rxAck;
  logic [W-1:0] outWord;
  logic         outValid;
  logic         codeErr;

  logic         loopback = 1'b1;
  logic [W-1:0] drvT = '0, drvF = '0;
  logic         drvAck = 1'b0;

  int nChecks = 0;
  int nBad = 0;
  bit done = 1'b0;
  logic [W-1:0] expQ[$];

  always #2 clk = ~clk;

  assign rxRailT = loopback ? txRailT : drvT;
  assign rxRailF = loopback ? txRailF : drvF;
  assign txAck   = loopback ? rxAck   : drvAck;

  dualrail_link #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .inWord(inWord), .inValid(inValid),
    .inReady(inReady), .txRailT(txRailT), .txRailF(txRailF),
    .txAck(txAck), .rxRailT(rxRailT), .rxRailF(rxRailF),
    .rxAck(rxAck), .outWord(outWord), .outValid(outValid),
    .codeErr(codeErr)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected words as tokens complete (R8)
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R8 unexpected outValid", {24'd0, outWord}, 32'd0);
      end else begin
        logic [W-1:0] e;
        e = expQ.pop_front();
        chk(outWord == e, "R8 outWord", {24'd0, outWord}, {24'd0, e});
      end
    end
  end

  // driver for loopback transfers
  task automatic sendWord(input logic [W-1:0] w);
    while (!inReady) @(negedge clk);
    inWord = w; inValid = 1'b1;
    expQ.push_back(w);
    @(negedge clk);
    chk(txRailT == w,  "R1 true rails",  {24'd0, txRailT}, {24'd0, w});
    chk(txRailF == ~w, "R1 false rails", {24'd0, txRailF}, {24'd0, ~w});
    chk(!inReady, "R3 busy not ready", {31'd0, inReady}, 32'd0);
    inWord = ~w;  // offered while busy, must be ignored
    @(negedge clk);
    chk(rxAck == 1'b1, "R6 ack on full word", {31'd0, rxAck}, 32'd1);
    chk(txRailT == w, "R3 busy offer ignored", {24'd0, txRailT}, {24'd0, w});
    inValid = 1'b0;
    @(negedge clk);
    chk(txRailT == '0 && txRailF == '0, "R4 spacer after ack",
        {16'd0, txRailT, txRailF}, 32'd0);
    @(negedge clk);
    chk(rxAck == 1'b0, "R7 ack drop on spacer", {31'd0, rxAck}, 32'd0);
    chk(!inReady, "R5 not ready before ack seen low", {31'd0, inReady}, 32'd0);
    @(negedge clk);
    chk(inReady, "R5 ready again", {31'd0, inReady}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nBad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txRailT == '0 && txRailF == '0, "R2 rails empty in reset",
        {16'd0, txRailT, txRailF}, 32'd0);
    chk(!rxAck && !outValid && !codeErr, "R2 outputs low in reset",
        {29'd0, rxAck, outValid, codeErr}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady, "R2 ready after reset", {31'd0, inReady}, 32'd1);

    // loopback traffic, several patterns
    sendWord(8'hA5);
    sendWord(8'h00);
    sendWord(8'hFF);
    sendWord(8'h3C);
    sendWord(8'h01);

    // manual: transmitter with ack held high while idle
    loopback = 1'b0;
    drvAck = 1'b1;
    @(negedge clk);
    inWord = 8'h77; inValid = 1'b1;
    chk(!inReady, "R3 not ready with ack high", {31'd0, inReady}, 32'd0);
    repeat (2) @(negedge clk);
    chk(txRailT == '0 && txRailF == '0, "R3 no load while ack high",
        {16'd0, txRailT, txRailF}, 32'd0);
    drvAck = 1'b0;
    @(negedge clk);  // accepted on this edge
    inValid = 1'b0;
    chk(txRailT == 8'h77 && txRailF == 8'h88, "R1 manual load",
        {16'd0, txRailT, txRailF}, 32'h7788);
    repeat (3) @(negedge clk);
    chk(txRailT == 8'h77, "R4 hold while ack low", {24'd0, txRailT}, 32'h77);
    drvAck = 1'b1;
    @(negedge clk);
    chk(txRailT == '0 && txRailF == '0, "R4 clear after ack",
        {16'd0, txRailT, txRailF}, 32'd0);
    repeat (3) @(negedge clk);
    chk(!inReady && txRailT == '0 && txRailF == '0, "R5 stay empty ack high",
        {15'd0, inReady, txRailT, txRailF}, 32'd0);
    drvAck = 1'b0;
    @(negedge clk);
    chk(inReady, "R5 ready after ack low", {31'd0, inReady}, 32'd1);

    // manual: receiver completion detection
    drvT = 8'h0A; drvF = 8'h00;  // half-filled
    repeat (2) @(negedge clk);
    chk(!rxAck && !outValid, "R6 no ack on partial word",
        {30'd0, rxAck, outValid}, 32'd0);
    expQ.push_back(8'h5A);
    drvT = 8'h5A; drvF = 8'hA5;
    @(negedge clk);
    chk(rxAck && outValid, "R8 pulse with ack rise",
        {30'd0, rxAck, outValid}, 32'd3);
    @(negedge clk);
    chk(!outValid, "R8 pulse one cycle", {31'd0, outValid}, 32'd0);
    drvT = 8'h50; drvF = 8'h00;  // partly returned to spacer
    repeat (2) @(negedge clk);
    chk(rxAck, "R7 ack held on partial spacer", {31'd0, rxAck}, 32'd1);
    drvT = '0; drvF = '0;
    @(negedge clk);
    chk(!rxAck, "R7 ack drop on full spacer", {31'd0, rxAck}, 32'd0);
    chk(!codeErr, "R9 no error yet", {31'd0, codeErr}, 32'd0);

    // illegal pair
    drvT = 8'hC3; drvF = 8'h3C | 8'h01;  // bit0 is (1,1)
    repeat (2) @(negedge clk);
    chk(!rxAck && !outValid, "R10 illegal word not complete",
        {30'd0, rxAck, outValid}, 32'd0);
    chk(codeErr, "R9 error flagged", {31'd0, codeErr}, 32'd1);
    drvT = '0; drvF = '0;
    repeat (3) @(negedge clk);
    chk(codeErr, "R9 error sticky", {31'd0, codeErr}, 32'd1);

    loopback = 1'b1;
    sendWord(8'h96);
    chk(codeErr, "R9 error sticky through traffic", {31'd0, codeErr}, 32'd1);

    rstN = 1'b0;
    @(negedge clk);
    chk(!codeErr, "R2 reset clears error", {31'd0, codeErr}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(expQ.size() == 0, "R8 all tokens delivered", expQ.size(), 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule